// File: doc/BRIEF.md
# DRAM Power-Up Sequencer and Refresh Scheduler

This block brings an asynchronous DRAM out of power-up and then keeps its contents alive. After reset it stays idle for a start-up interval and then runs a fixed train of refresh cycles. Only then does it raise `initDone`, which tells the access sequencer that ordinary reads and writes may begin. The block drives its own row and column strobes, and every refresh it issues is of the column-before-row kind. The DRAM supplies the row address from its internal counter, so the address, write-enable and output-enable lines are left to the access sequencer and the data pins stay open.

After initialisation a countdown timer makes one refresh due every `INTERVAL_CYC` cycles. That spreads the required number of refreshes evenly over the retention period. Due refreshes collect in a saturating pending counter. While that counter is non-zero the block raises `refReq`. The access sequencer finishes whatever access it has in flight and then answers with `refGrant`, which it holds for as long as `refReq` stays high. When the pending count reaches `MAX_PEND`, `refUrgent` tells the sequencer's arbiter to stop postponing. Every strobe width is a whole number of clock cycles set by a parameter, chosen by the integrator to cover the DRAM's nanosecond minimums at the clock rate in use.

Top module: `dramRefSched`

## Requirements
- R1: While `rstN` is low, `rasN` and `casN` are high and `initDone`, `refReq` and `refUrgent` are low.
- R2: For the first `STARTUP_CYC` clock edges after reset is released, both strobes stay high. `casN` goes low right after edge `STARTUP_CYC`.
- R3: Initialisation runs exactly `INIT_REFS` refresh cycles back to back, each `CAS_LEAD+RAS_LOW+RAS_PRE` cycles long, without waiting for `refGrant`. `initDone` rises right after edge `STARTUP_CYC+INIT_REFS*(CAS_LEAD+RAS_LOW+RAS_PRE)`.
- R4: In every refresh, `casN` is low for exactly `CAS_LEAD` cycles before `rasN` falls. It stays low for `CAS_HOLD` cycles after `rasN` falls and returns high before `rasN` rises. `casN` only ever falls while `rasN` is high.
- R5: `rasN` stays low for exactly `RAS_LOW` cycles per refresh. Between two refreshes it stays high for at least `RAS_PRE+CAS_LEAD` cycles.
- R6: Once `initDone` is high, one refresh becomes due every `INTERVAL_CYC` cycles, the first `INTERVAL_CYC` cycles after `initDone` rises. With `refGrant` held high, consecutive `rasN` falls are exactly `INTERVAL_CYC` cycles apart.
- R7: `refReq` is high whenever at least one refresh is pending or a refresh cycle is under way, and low otherwise.
- R8: After `initDone`, a refresh cycle starts only when `refGrant` is high in the cycle before `casN` falls. With `refGrant` low, no strobe moves.
- R9: The pending count saturates at `MAX_PEND`. `refUrgent` is high exactly while the count equals `MAX_PEND`. A grant after saturation yields exactly `MAX_PEND` refreshes, one idle cycle apart, and no more.
- R10: `initDone` never falls once set, and `refReq` and `refUrgent` are high only while `initDone` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refGrant | input | 1 | Access sequencer hands the DRAM bus to this block |
| refReq | output | 1 | Refresh pending or in progress; bus wanted |
| refUrgent | output | 1 | Pending count at its limit; refresh must win arbitration |
| rasN | output | 1 | Row strobe to the DRAM, active low |
| casN | output | 1 | Column strobe to the DRAM, active low |
| initDone | output | 1 | Power-up sequence complete; accesses allowed |

## Verification
The bound checker enforces the strobe ordering on every cycle: column strobe low whenever the row strobe falls, column strobe falling only with the row strobe high, and column strobe released before the row strobe rises. It also checks on every cycle that no refresh starts without a grant once initialised, that `initDone` is sticky, and that the request and urgency flags stay consistent with it. Exact pulse widths, the start-up wait, the length of the initialisation train, the refresh interval, and the saturation-then-drain behaviour of the pending counter are only shown by the bench. The bench predicts the cycle of every row-strobe fall arithmetically and compares the recorded falls against that prediction.

// File: rtl/dramRefPkg.sv
package dramRefPkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_IDLE,
    ST_CAS,
    ST_RAS,
    ST_PRE
  } refState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrPhase;   // restart the phase counter
    logic initStep;   // one initialisation refresh completed
    logic retire;     // one scheduled refresh completed
    logic timerRun;   // interval timer may count
  } refCtrl_t;

endpackage

// File: rtl/dramRefDatapath.sv
module dramRefDatapath
  import dramRefPkg::*;
#(
  parameter int STARTUP_CYC  = 20000,
  parameter int INIT_REFS    = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int MAX_PEND     = 8,
  parameter int PH_W         = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  refCtrl_t        ctrl,
  output logic            startDone,
  output logic            initLast,
  output logic [PH_W-1:0] phase,
  output logic            pendAny,
  output logic            pendFull
);

  localparam int SU_W = (STARTUP_CYC > 1) ? $clog2(STARTUP_CYC) : 1;
  localparam int IN_W = (INIT_REFS > 1) ? $clog2(INIT_REFS) : 1;
  localparam int TM_W = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
  localparam int PD_W = $clog2(MAX_PEND + 1);
  localparam logic [SU_W-1:0] SU_LAST  = SU_W'(STARTUP_CYC - 1);
  localparam logic [IN_W-1:0] IN_LAST  = IN_W'(INIT_REFS - 1);
  localparam logic [TM_W-1:0] TM_LOAD  = TM_W'(INTERVAL_CYC - 1);
  localparam logic [PD_W-1:0] PD_LIMIT = PD_W'(MAX_PEND);

  logic [SU_W-1:0] startCnt;
  logic [IN_W-1:0] initCnt;
  logic [TM_W-1:0] timer;
  logic [PD_W-1:0] pendCnt;
  logic            tick;

  assign startDone = (startCnt == SU_LAST);
  assign initLast  = (initCnt == IN_LAST);
  assign tick      = ctrl.timerRun && (timer == '0);
  assign pendAny   = (pendCnt != '0);
  assign pendFull  = (pendCnt == PD_LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startCnt <= '0;
      initCnt  <= '0;
      phase    <= '0;
      timer    <= TM_LOAD;
    end else begin
      if (!startDone) startCnt <= startCnt + 1'b1;
      if (ctrl.initStep) initCnt <= initCnt + 1'b1;
      phase <= ctrl.clrPhase ? '0 : phase + 1'b1;
      if (!ctrl.timerRun || tick) timer <= TM_LOAD;
      else                        timer <= timer - 1'b1;
    end
  end

  // pending refreshes: saturate at the limit, never below zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCnt <= '0;
    end else begin
      unique case ({tick, ctrl.retire})
        2'b10:   if (!pendFull) pendCnt <= pendCnt + 1'b1;
        2'b01:   if (pendAny)   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
    end
  end

endmodule

// File: rtl/dramRefControl.sv
module dramRefControl
  import dramRefPkg::*;
#(
  parameter int CAS_LEAD = 1,
  parameter int CAS_HOLD = 1,
  parameter int RAS_LOW  = 5,
  parameter int RAS_PRE  = 4,
  parameter int PH_W     = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            refGrant,
  input  logic            startDone,
  input  logic            initLast,
  input  logic [PH_W-1:0] phase,
  input  logic            pendAny,
  input  logic            pendFull,
  output refCtrl_t        ctrl,
  output logic            refReq,
  output logic            refUrgent,
  output logic            rasN,
  output logic            casN,
  output logic            initDone
);

  localparam logic [PH_W-1:0] CL_LAST = PH_W'(CAS_LEAD - 1);
  localparam logic [PH_W-1:0] RL_LAST = PH_W'(RAS_LOW - 1);
  localparam logic [PH_W-1:0] RP_LAST = PH_W'(RAS_PRE - 1);
  localparam logic [PH_W-1:0] CH_LIM  = PH_W'(CAS_HOLD);

  refState_t state, nextState;
  logic      setDone;

  always_comb begin
    nextState     = state;
    setDone       = 1'b0;
    ctrl.initStep = 1'b0;
    ctrl.retire   = 1'b0;
    unique case (state)
      ST_WAIT: if (startDone) nextState = ST_CAS;
      ST_IDLE: if (pendAny && refGrant) nextState = ST_CAS;
      ST_CAS:  if (phase == CL_LAST) nextState = ST_RAS;
      ST_RAS:  if (phase == RL_LAST) nextState = ST_PRE;
      ST_PRE: begin
        if (phase == RP_LAST) begin
          if (!initDone) begin
            ctrl.initStep = 1'b1;
            if (initLast) begin
              setDone   = 1'b1;
              nextState = ST_IDLE;
            end else begin
              nextState = ST_CAS;
            end
          end else begin
            ctrl.retire = 1'b1;
            nextState   = ST_IDLE;
          end
        end
      end
      default: nextState = ST_WAIT;
    endcase
    ctrl.clrPhase = (nextState != state) || (state == ST_WAIT) || (state == ST_IDLE);
    ctrl.timerRun = initDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_WAIT;
      initDone <= 1'b0;
    end else begin
      state <= nextState;
      if (setDone) initDone <= 1'b1;
    end
  end

  // strobe decode from registered state
  assign rasN      = (state != ST_RAS);
  assign casN      = !((state == ST_CAS) || ((state == ST_RAS) && (phase < CH_LIM)));
  assign refReq    = initDone && (pendAny || (state != ST_IDLE));
  assign refUrgent = initDone && pendFull;

endmodule

// File: rtl/dramRefSched.sv
module dramRefSched
  import dramRefPkg::*;
#(
  parameter int STARTUP_CYC  = 20000,
  parameter int INIT_REFS    = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int MAX_PEND     = 8,
  parameter int CAS_LEAD     = 1,
  parameter int CAS_HOLD     = 1,
  parameter int RAS_LOW      = 5,
  parameter int RAS_PRE      = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGrant,
  output logic refReq,
  output logic refUrgent,
  output logic rasN,
  output logic casN,
  output logic initDone
);

  localparam int PH_MAX = (CAS_LEAD > RAS_LOW) ?
                          ((CAS_LEAD > RAS_PRE) ? CAS_LEAD : RAS_PRE) :
                          ((RAS_LOW > RAS_PRE) ? RAS_LOW : RAS_PRE);
  localparam int PH_W = $clog2(PH_MAX + 1);

  refCtrl_t        ctrl;
  logic            startDone, initLast, pendAny, pendFull;
  logic [PH_W-1:0] phase;

  dramRefControl #(
    .CAS_LEAD(CAS_LEAD), .CAS_HOLD(CAS_HOLD), .RAS_LOW(RAS_LOW),
    .RAS_PRE(RAS_PRE), .PH_W(PH_W)
  ) ctlI (
    .clk(clk), .rstN(rstN), .refGrant(refGrant),
    .startDone(startDone), .initLast(initLast), .phase(phase),
    .pendAny(pendAny), .pendFull(pendFull), .ctrl(ctrl),
    .refReq(refReq), .refUrgent(refUrgent), .rasN(rasN), .casN(casN),
    .initDone(initDone)
  );

  dramRefDatapath #(
    .STARTUP_CYC(STARTUP_CYC), .INIT_REFS(INIT_REFS),
    .INTERVAL_CYC(INTERVAL_CYC), .MAX_PEND(MAX_PEND), .PH_W(PH_W)
  ) dpI (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .startDone(startDone), .initLast(initLast), .phase(phase),
    .pendAny(pendAny), .pendFull(pendFull)
  );

endmodule

// File: rtl/dramRefSchedChk.sv
module dramRefSchedChk (
  input logic clk,
  input logic rstN,
  input logic refGrant,
  input logic refReq,
  input logic refUrgent,
  input logic rasN,
  input logic casN,
  input logic initDone
);

  // R4
  cas_before_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> !casN);

  // R4
  cas_fall_ras_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> rasN);

  // R4
  cas_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> casN);

  // R8
  no_grant_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && !refGrant && rasN && casN) |=> casN);

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  // R10
  req_needs_init_chk: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> initDone);

  // R9
  urgent_implies_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    refUrgent |-> refReq);

endmodule

bind dramRefSched dramRefSchedChk chkI (
  .clk(clk), .rstN(rstN), .refGrant(refGrant), .refReq(refReq),
  .refUrgent(refUrgent), .rasN(rasN), .casN(casN), .initDone(initDone)
);

// File: tb/dramRefSched_test.sv
module dramRefSched_test;

  localparam int SU   = 50;
  localparam int NI   = 8;
  localparam int IV   = 60;
  localparam int MP   = 3;
  localparam int CL   = 2;
  localparam int CH   = 2;
  localparam int RL   = 4;
  localparam int RP   = 3;
  localparam int LEN  = CL + RL + RP;
  localparam int E0   = SU + NI * LEN;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGrant = 1'b0;
  logic refReq, refUrgent, rasN, casN, initDone;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nFall = 0;
  int fallCyc [0:31];
  bit finished = 1'b0;

  dramRefSched #(
    .STARTUP_CYC(SU), .INIT_REFS(NI), .INTERVAL_CYC(IV), .MAX_PEND(MP),
    .CAS_LEAD(CL), .CAS_HOLD(CH), .RAS_LOW(RL), .RAS_PRE(RP)
  ) uut (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .refReq(refReq),
    .refUrgent(refUrgent), .rasN(rasN), .casN(casN), .initDone(initDone)
  );

  always #2 clk = ~clk;

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  task automatic waitCyc(input int n);
    do @(negedge clk); while (cyc < n);
  endtask

  // strobe monitor, sampled at the falling edge
  bit prevRas = 1'b1, prevCas = 1'b1;
  int casLowRun = 0, rasLowRun = 0, rasHighRun = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevRas && !rasN) begin
        chk(!casN && casLowRun == CL, "R4 cas lead before ras fall", casLowRun, CL);
        if (nFall > 0)
          chk(rasHighRun >= RP + CL, "R5 ras high between cycles", rasHighRun, RP + CL);
        if (nFall < 32) fallCyc[nFall] = cyc;
        nFall++;
      end
      if (!prevRas && rasN)
        chk(rasLowRun == RL, "R5 ras low width", rasLowRun, RL);
      if (!prevCas && casN)
        chk(casLowRun == CL + CH, "R4 cas low width", casLowRun, CL + CH);
      if (prevCas && !casN && initDone)
        chk(refGrant, "R8 cas fall needs grant", refGrant, 1);
      casLowRun  = casN ? 0 : casLowRun + 1;
      rasLowRun  = rasN ? 0 : rasLowRun + 1;
      rasHighRun = rasN ? rasHighRun + 1 : 0;
      prevRas = rasN;
      prevCas = casN;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(rasN && casN, "R1 strobes high in reset", {rasN, casN}, 3);
    chk(!initDone && !refReq && !refUrgent, "R1 flags low in reset",
        {initDone, refReq, refUrgent}, 0);
    rstN = 1'b1;

    // R2: strobes idle through the start-up wait
    begin
      int bad = 0;
      for (int i = 1; i < SU; i++) begin
        waitCyc(i);
        if (!rasN || !casN) bad++;
      end
      chk(bad == 0, "R2 strobes idle during start-up", bad, 0);
    end
    waitCyc(SU);
    chk(!casN && rasN, "R2 first cas fall at start-up end", casN, 0);

    // R3: initialisation train
    waitCyc(E0 - 1);
    chk(!initDone, "R3 initDone low before train ends", initDone, 0);
    chk(nFall == NI, "R3 init refresh count", nFall, NI);
    for (int i = 0; i < NI; i++)
      chk(fallCyc[i] == SU + i * LEN + CL, "R3 init ras fall cycle", fallCyc[i], SU + i * LEN + CL);
    waitCyc(E0);
    chk(initDone, "R3 initDone after train", initDone, 1);
    chk(!refReq, "R7 no request without pending", refReq, 0);

    // R6/R7: first due refresh
    waitCyc(E0 + IV - 1);
    chk(!refReq, "R6 nothing due before interval", refReq, 0);
    waitCyc(E0 + IV);
    chk(refReq, "R6 refresh due after interval", refReq, 1);
    chk(!refUrgent, "R9 not urgent at one pending", refUrgent, 0);

    // R9: saturation
    waitCyc(E0 + MP * IV - 1);
    chk(!refUrgent, "R9 urgent low below limit", refUrgent, 0);
    waitCyc(E0 + MP * IV);
    chk(refUrgent, "R9 urgent at limit", refUrgent, 1);
    waitCyc(E0 + 12 * IV);
    chk(nFall == NI, "R8 no refresh without grant", nFall, NI);
    chk(refUrgent && refReq, "R9 still urgent while saturated", refUrgent, 1);
    refGrant = 1'b1;
    waitCyc(E0 + 12 * IV + 28);
    chk(refReq, "R7 request held through last cycle", refReq, 1);
    waitCyc(E0 + 12 * IV + 30);
    chk(!refReq, "R7 request drops when drained", refReq, 0);
    waitCyc(E0 + 12 * IV + 50);
    chk(nFall == NI + MP, "R9 burst equals limit", nFall, NI + MP);
    chk(!refUrgent, "R9 urgent clears after drain", refUrgent, 0);
    for (int j = 0; j < MP; j++)
      chk(fallCyc[NI + j] == E0 + 12 * IV + 1 + j * (LEN + 1) + CL,
          "R9 burst ras fall cycle", fallCyc[NI + j], E0 + 12 * IV + 1 + j * (LEN + 1) + CL);

    // R6: steady spacing with grant held
    waitCyc(E0 + 17 * IV + 20);
    chk(nFall == NI + MP + 5, "R6 steady refresh count", nFall, NI + MP + 5);
    for (int j = 0; j < 5; j++)
      chk(fallCyc[NI + MP + j] == E0 + (13 + j) * IV + 1 + CL,
          "R6 steady ras fall cycle", fallCyc[NI + MP + j], E0 + (13 + j) * IV + 1 + CL);
    chk(initDone, "R10 initDone still high", initDone, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, E0 + 17 * IV + 20);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule